// File: doc/BRIEF.md
# Compressed Instruction Line Decompressor

This block sits on the memory side of an instruction cache. On every line fill it rebuilds a line of 32-bit instructions from a packed bitstream. Each instruction is stored as two variable-length codewords. The codeword for the upper halfword comes first, then the codeword for the lower halfword. Each half is expanded through its own 1024-entry, 16-bit lookup table. Short codewords select table entries. A long escape carries a raw 16-bit literal. The shortest lower-half code stands for an all-zero halfword and reads no table. The cache and the core only ever see ordinary 32-bit instructions.

A fill request carries a bypass flag. When the flag is set, the line is passed through as raw 32-bit words, with memory flow control following the output side. Both lookup tables are loaded through a write port while the block is idle. The instruction output uses valid/ready backpressure and marks the final word of each line.

The controller is a state machine with five states: `S_IDLE`, `S_UPPER`, `S_LOWER`, `S_EMIT` and `S_RAW`.
- `S_IDLE` goes to `S_RAW` when a fill is accepted with bypass set, and to `S_UPPER` when a fill is accepted with bypass clear.
- `S_UPPER` goes to `S_LOWER` when the upper codeword is consumed.
- `S_LOWER` goes to `S_EMIT` when the lower codeword is consumed.
- `S_EMIT` goes back to `S_UPPER` on an output handshake that is not the final word. It goes to `S_IDLE` on the handshake of the final word, which also discards the padding bits left in the buffer.
- `S_RAW` goes to `S_IDLE` on the handshake of the final raw word.

Top module: `codeline_expander`

## Requirements
- R1: Upper-half codewords are read MSB-first. The classes are:
  - prefix 00 plus a 3-bit index (5 bits), giving table entry index
  - prefix 01 plus a 6-bit index (8 bits), giving entry index
  - prefix 10 plus a 10-bit index (12 bits), giving entry index
  - prefix 110 plus a 9-bit index (12 bits), giving entry 512+index
  - prefix 111 plus a 16-bit literal (19 bits), giving the literal itself
- R2: Lower-half codewords use these classes:
  - prefix 00 (2 bits), giving 16'h0000 with no table read
  - prefix 01 plus a 4-bit index (6 bits), giving lower entry index
  - prefix 10 plus a 10-bit index (12 bits), giving entry index
  - prefix 110 plus an 8-bit index (11 bits), giving entry index
  - prefix 111 plus a 16-bit literal (19 bits), giving the literal
- R3: The stream is consumed MSB-first from 32-bit memory words. A codeword may straddle a word boundary. Each output word is {upper half, lower half}.
- R4: Every fill produces exactly LINE_WORDS (16) output words. out_last is high on the final word and only on it.
- R5: A memory word is accepted only when the buffered bits cannot yet complete the pending codeword. No word beyond the line's packed length is taken, and pad bits after the last codeword are discarded.
- R6: With bypass set, the sixteen memory words appear unchanged on the output, and mem_ready equals out_ready.
- R7: A table write (tbl_sel 0 = upper, 1 = lower) takes effect while idle. A write presented during a fill is ignored.
- R8: While out_valid is high and out_ready is low, out_valid and out_data hold their values.
- R9: After reset and between fills, fill_ready is high and out_valid and mem_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fill_valid | input | 1 | Line fill request |
| fill_bypass | input | 1 | Line is stored raw |
| fill_ready | output | 1 | Block idle, request accepted |
| mem_valid | input | 1 | Memory word valid |
| mem_data | input | 32 | Memory word |
| mem_ready | output | 1 | Memory word taken |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 1 | 0 upper table, 1 lower table |
| tbl_addr | input | 10 | Table entry |
| tbl_data | input | 16 | Table entry value |
| out_valid | output | 1 | Instruction valid |
| out_data | output | 32 | Rebuilt instruction |
| out_last | output | 1 | Final word of the line |
| out_ready | input | 1 | Consumer accepts instruction |

## Verification
The bench builds the block with its default line of 16 words and full 1024-entry tables, and loads every table entry from a formula. The bench then sweeps all 25 pairings of upper and lower codeword classes across lines in which codewords land at every bit offset relative to word boundaries. It also runs a densely packed line of 7-bit instructions, lines with table writes attempted mid-fill, and bypass lines under irregular ready and valid patterns. Junk words offered after each line's real data expose any over-fetch.

// File: rtl/cle_pkg.sv
package cle_pkg;
    localparam int HALF_W    = 16;
    localparam int WORD_W    = 32;
    localparam int TBL_DEPTH = 1024;
    localparam int TBL_AW    = $clog2(TBL_DEPTH);
    localparam int PEEK_W    = 19;
    localparam int LEN_W     = 5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_UPPER,
        S_LOWER,
        S_EMIT,
        S_RAW
    } state_t;

    // one decoded codeword: its length, where its value comes from
    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic              use_tbl;
        logic [TBL_AW-1:0] addr;
        logic [HALF_W-1:0] lit;
    } cw_t;
endpackage

// File: rtl/cle_bitbuf.sv
module cle_bitbuf
    import cle_pkg::*;
#(
    parameter int BUF_W = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [WORD_W-1:0]          word,
    input  logic                       consume,
    input  logic [LEN_W-1:0]           len,
    input  logic                       clear,
    output logic [PEEK_W-1:0]          peek,
    output logic [$clog2(BUF_W+1)-1:0] count
);
    localparam int CNT_W = $clog2(BUF_W+1);

    logic [BUF_W-1:0] buf_q;

    // left-aligned: bit BUF_W-1 is the next stream bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
            count <= '0;
        end else if (clear) begin
            buf_q <= '0;
            count <= '0;
        end else if (load) begin
            buf_q <= buf_q | ({word, {(BUF_W-WORD_W){1'b0}}} >> count);
            count <= count + CNT_W'(WORD_W);
        end else if (consume) begin
            buf_q <= buf_q << len;
            count <= count - CNT_W'(len);
        end
    end

    assign peek = buf_q[BUF_W-1 -: PEEK_W];
endmodule

// File: rtl/cle_halfdec.sv
module cle_halfdec
    import cle_pkg::*;
#(
    parameter bit UPPER = 1'b1
) (
    input  logic [PEEK_W-1:0] peek,
    output cw_t               cw
);
    generate
        if (UPPER) begin : g_upper
            always_comb begin
                cw = '0;
                cw.use_tbl = 1'b1;
                unique case (peek[18:17])
                    2'b00: begin cw.len = 5'd5;  cw.addr = TBL_AW'(peek[16:14]); end
                    2'b01: begin cw.len = 5'd8;  cw.addr = TBL_AW'(peek[16:11]); end
                    2'b10: begin cw.len = 5'd12; cw.addr = peek[16:7]; end
                    default: begin
                        if (!peek[16]) begin
                            cw.len  = 5'd12;
                            cw.addr = {1'b1, peek[15:7]};
                        end else begin
                            cw.len     = 5'd19;
                            cw.use_tbl = 1'b0;
                            cw.lit     = peek[15:0];
                        end
                    end
                endcase
            end
        end else begin : g_lower
            always_comb begin
                cw = '0;
                cw.use_tbl = 1'b1;
                unique case (peek[18:17])
                    2'b00: begin cw.len = 5'd2; cw.use_tbl = 1'b0; end
                    2'b01: begin cw.len = 5'd6;  cw.addr = TBL_AW'(peek[16:13]); end
                    2'b10: begin cw.len = 5'd12; cw.addr = peek[16:7]; end
                    default: begin
                        if (!peek[16]) begin
                            cw.len  = 5'd11;
                            cw.addr = TBL_AW'(peek[15:8]);
                        end else begin
                            cw.len     = 5'd19;
                            cw.use_tbl = 1'b0;
                            cw.lit     = peek[15:0];
                        end
                    end
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/cle_xtable.sv
module cle_xtable #(
    parameter int DEPTH = 1024,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/codeline_expander.sv
module codeline_expander
    import cle_pkg::*;
#(
    parameter int LINE_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_valid,
    input  logic              fill_bypass,
    output logic              fill_ready,
    input  logic              mem_valid,
    input  logic [WORD_W-1:0] mem_data,
    output logic              mem_ready,
    input  logic              tbl_we,
    input  logic              tbl_sel,
    input  logic [TBL_AW-1:0] tbl_addr,
    input  logic [HALF_W-1:0] tbl_data,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last,
    input  logic              out_ready
);
    localparam int IDX_W = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1;
    localparam int BUF_W = 64;
    localparam int CNT_W = $clog2(BUF_W+1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_WORDS-1);

    state_t            state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [HALF_W-1:0] hi_q, lo_q;
    logic [PEEK_W-1:0] peek;
    logic [CNT_W-1:0]  count;
    cw_t               cw_hi, cw_lo, cw_act;
    logic [HALF_W-1:0] rd_hi, rd_lo, half_val;
    logic [LEN_W-1:0]  need;
    logic known, decoding, fetch, load, consume, clear;
    logic fill_go, out_go, raw_go, at_last;

    cle_bitbuf #(.BUF_W(BUF_W)) bitbuf_i (
        .clk(clk), .rst_n(rst_n), .load(load), .word(mem_data),
        .consume(consume), .len(cw_act.len), .clear(clear),
        .peek(peek), .count(count)
    );

    cle_halfdec #(.UPPER(1'b1)) dec_hi_i (.peek(peek), .cw(cw_hi));
    cle_halfdec #(.UPPER(1'b0)) dec_lo_i (.peek(peek), .cw(cw_lo));

    cle_xtable #(.DEPTH(TBL_DEPTH), .W(HALF_W)) tbl_hi_i (
        .clk(clk), .we(tbl_we && !tbl_sel && state_q == S_IDLE),
        .waddr(tbl_addr), .wdata(tbl_data), .raddr(cw_hi.addr), .rdata(rd_hi)
    );
    cle_xtable #(.DEPTH(TBL_DEPTH), .W(HALF_W)) tbl_lo_i (
        .clk(clk), .we(tbl_we && tbl_sel && state_q == S_IDLE),
        .waddr(tbl_addr), .wdata(tbl_data), .raddr(cw_lo.addr), .rdata(rd_lo)
    );

    // codeword length resolution and demand-driven refill
    always_comb begin
        decoding = (state_q == S_UPPER) || (state_q == S_LOWER);
        cw_act   = (state_q == S_LOWER) ? cw_lo : cw_hi;
        known    = (count >= CNT_W'(3)) ||
                   ((count == CNT_W'(2)) && (peek[PEEK_W-1 -: 2] != 2'b11));
        if (known)                  need = cw_act.len;
        else if (count < CNT_W'(2)) need = LEN_W'(2);
        else                        need = LEN_W'(3);
        fetch    = decoding && (count < CNT_W'(need));
        consume  = decoding && !fetch;
        load     = fetch && mem_valid;
        half_val = cw_act.use_tbl ? ((state_q == S_LOWER) ? rd_lo : rd_hi)
                                  : cw_act.lit;
        at_last  = (idx_q == LAST_IDX);
        fill_go  = fill_valid && fill_ready;
        out_go   = out_valid && out_ready;
        raw_go   = (state_q == S_RAW) && mem_valid && out_ready;
        clear    = (state_q == S_EMIT) && out_ready && at_last;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (fill_go) state_d = fill_bypass ? S_RAW : S_UPPER;
            S_UPPER: if (consume) state_d = S_LOWER;
            S_LOWER: if (consume) state_d = S_EMIT;
            S_EMIT:  if (out_go)  state_d = at_last ? S_IDLE : S_UPPER;
            S_RAW:   if (raw_go && at_last) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            hi_q  <= '0;
            lo_q  <= '0;
        end else begin
            if (fill_go)                            idx_q <= '0;
            else if ((state_q == S_EMIT && out_go) || raw_go) idx_q <= idx_q + 1'b1;
            if (state_q == S_UPPER && consume) hi_q <= half_val;
            if (state_q == S_LOWER && consume) lo_q <= half_val;
        end
    end

    // outputs
    always_comb begin
        fill_ready = 1'b0;
        mem_ready  = 1'b0;
        out_valid  = 1'b0;
        out_data   = {hi_q, lo_q};
        out_last   = 1'b0;
        unique case (state_q)
            S_IDLE:  fill_ready = 1'b1;
            S_UPPER, S_LOWER: mem_ready = fetch;
            S_EMIT: begin
                out_valid = 1'b1;
                out_last  = at_last;
            end
            S_RAW: begin
                mem_ready = out_ready;
                out_valid = mem_valid;
                out_data  = mem_data;
                out_last  = at_last;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cle_checker.sv
module cle_checker #(
    parameter int LINE_WORDS = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        fill_valid,
    input logic        fill_bypass,
    input logic        fill_ready,
    input logic        mem_valid,
    input logic [31:0] mem_data,
    input logic        mem_ready,
    input logic        out_valid,
    input logic [31:0] out_data,
    input logic        out_last,
    input logic        out_ready
);
    localparam int CW = $clog2(LINE_WORDS+1);

    logic          byp_q;
    logic [CW-1:0] ocnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byp_q <= 1'b0;
            ocnt  <= '0;
        end else if (fill_valid && fill_ready) begin
            byp_q <= fill_bypass;
            ocnt  <= '0;
        end else if (out_valid && out_ready) begin
            ocnt <= ocnt + 1'b1;
        end
    end

    assert_last_only_final_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (ocnt == CW'(LINE_WORDS-1)));

    assert_final_has_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ocnt == CW'(LINE_WORDS-1)) |-> out_last);

    assert_no_extra_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (ocnt < CW'(LINE_WORDS)));

    assert_hold_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp_q && out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_raw_passthrough_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (byp_q && out_valid) |-> (out_data == mem_data));

    assert_raw_flow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (byp_q && !fill_ready) |-> (mem_ready == out_ready && out_valid == mem_valid));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ready |-> (!out_valid && !mem_ready));
endmodule

bind codeline_expander cle_checker #(.LINE_WORDS(LINE_WORDS)) chk_i (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_bypass(fill_bypass),
    .fill_ready(fill_ready), .mem_valid(mem_valid), .mem_data(mem_data),
    .mem_ready(mem_ready), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_ready(out_ready)
);

// File: tb/codeline_expander_tb_top.sv
`timescale 1ns/100ps
module codeline_expander_tb_top;
    localparam int LW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fill_valid = 1'b0, fill_bypass = 1'b0, fill_ready;
    logic mem_valid = 1'b0, mem_ready;
    logic [31:0] mem_data = '0;
    logic tbl_we = 1'b0, tbl_sel = 1'b0;
    logic [9:0] tbl_addr = '0;
    logic [15:0] tbl_data = '0;
    logic out_valid, out_last, out_ready = 1'b0;
    logic [31:0] out_data;

    always #2.5 clk = ~clk;

    codeline_expander #(.LINE_WORDS(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_bypass(fill_bypass),
        .fill_ready(fill_ready), .mem_valid(mem_valid), .mem_data(mem_data),
        .mem_ready(mem_ready), .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr),
        .tbl_data(tbl_data), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .out_ready(out_ready)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [15:0] hi_m [1024];
    logic [15:0] lo_m [1024];
    logic [31:0] words [64];
    logic [31:0] exp_out [LW];
    bit          bits [0:1023];
    int nwords, nbits, sent, junk;
    bit line_done;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] hi_fn(input int a);
        return 16'((a * 40503 + 4660));
    endfunction
    function automatic logic [15:0] lo_fn(input int a);
        return 16'((a * 9973) ^ 48879);
    endfunction

    task automatic put(input logic [18:0] v, input int len);
        for (int k = len - 1; k >= 0; k--) begin
            bits[nbits] = v[k];
            nbits++;
        end
    endtask

    // builds one packed line; dense selects 7-bit instructions throughout
    task automatic build_line(input int ln, input bit dense);
        logic [15:0] hv, lv;
        nbits = 0;
        for (int i = 0; i < LW; i++) begin
            int uc, lc, s;
            uc = dense ? 0 : (i + ln) % 5;
            lc = dense ? 0 : (i * 3 + ln * 2) % 5;
            s  = i * 37 + ln * 101 + 13;
            case (uc)
                0: begin put({14'b0, 2'b00, 3'(s % 8)}, 5);        hv = hi_m[s % 8]; end
                1: begin put({11'b0, 2'b01, 6'(s % 64)}, 8);       hv = hi_m[s % 64]; end
                2: begin put({7'b0, 2'b10, 10'(s % 1024)}, 12);    hv = hi_m[s % 1024]; end
                3: begin put({7'b0, 3'b110, 9'(s % 512)}, 12);     hv = hi_m[512 + s % 512]; end
                default: begin hv = 16'(s * 7919); put({3'b111, hv}, 19); end
            endcase
            case (lc)
                0: begin put(19'b00, 2);                            lv = 16'h0000; end
                1: begin put({13'b0, 2'b01, 4'(s % 16)}, 6);        lv = lo_m[s % 16]; end
                2: begin put({7'b0, 2'b10, 10'((s * 5) % 1024)}, 12); lv = lo_m[(s * 5) % 1024]; end
                3: begin put({8'b0, 3'b110, 8'(s % 256)}, 11);      lv = lo_m[s % 256]; end
                default: begin lv = 16'(s * 3571 + 1); put({3'b111, lv}, 19); end
            endcase
            exp_out[i] = {hv, lv};
        end
        nwords = (nbits + 31) / 32;
        for (int w = 0; w < nwords; w++) begin
            for (int b = 0; b < 32; b++) begin
                int pos;
                pos = w * 32 + b;
                words[w][31 - b] = (pos < nbits) ? bits[pos] : 1'b1;
            end
        end
    endtask

    task automatic build_raw(input int seed);
        nwords = LW;
        for (int i = 0; i < LW; i++) begin
            words[i]   = 32'(i * 32'h01010101 + seed * 32'h00370011 + 32'h9000_0005);
            exp_out[i] = words[i];
        end
    endtask

    task automatic drive_mem(input int seed);
        bit offered;
        offered = 1'b0;
        sent = 0;
        junk = 0;
        while (!line_done) begin
            @(negedge clk);
            if (!offered && ((cyc * 7 + seed) % 5 == 0)) begin
                mem_valid = 1'b0;
            end else begin
                mem_valid = 1'b1;
                mem_data  = (sent < nwords) ? words[sent] : 32'hFFFF_FFFF;
            end
            #1;
            if (mem_valid && mem_ready) begin
                if (sent < nwords) sent++;
                else junk++;
                offered = 1'b0;
            end else begin
                offered = mem_valid;
            end
        end
        mem_valid = 1'b0;
    endtask

    task automatic watch_out(input int seed, input string req);
        int got;
        got = 0;
        while (got < LW) begin
            @(negedge clk);
            out_ready = ((cyc * 3 + seed) % 4 != 0);
            #1;
            if (out_valid && out_ready) begin
                chk(out_data == exp_out[got], req, $sformatf("word %0d data", got),
                    out_data, exp_out[got]);
                chk(out_last == (got == LW - 1), "R4", $sformatf("word %0d last", got),
                    32'(out_last), 32'(got == LW - 1));
                got++;
            end
        end
        line_done = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic garbage_writes();
        repeat (3) @(negedge clk);
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            tbl_we   = 1'b1;
            tbl_sel  = a[0];
            tbl_addr = 10'(a / 2);
            tbl_data = 16'hDEAD;
        end
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic run_line(input bit bypass, input int seed, input bit junk_wr, input string req);
        line_done = 1'b0;
        @(negedge clk);
        fill_valid  = 1'b1;
        fill_bypass = bypass;
        #1;
        chk(fill_ready == 1'b1, "R9", "fill_ready before fill", 32'(fill_ready), 32'd1);
        @(negedge clk);
        fill_valid = 1'b0;
        fork
            drive_mem(seed);
            watch_out(seed, req);
            if (junk_wr) garbage_writes();
        join
        #1;
        chk(sent == nwords, "R5", "memory words consumed", 32'(sent), 32'(nwords));
        chk(junk == 0, "R5", "words taken beyond line", 32'(junk), 32'd0);
        @(negedge clk);
        #1;
        chk(fill_ready && !out_valid && !mem_ready, "R9", "idle after line",
            {29'b0, fill_ready, out_valid, mem_ready}, 32'd4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int a = 0; a < 1024; a++) begin
            hi_m[a] = hi_fn(a);
            lo_m[a] = lo_fn(a);
        end
        repeat (4) @(negedge clk);
        #1;
        chk(fill_ready && !out_valid && !mem_ready, "R9", "reset state",
            {29'b0, fill_ready, out_valid, mem_ready}, 32'd4);
        rst_n = 1'b1;

        // load both tables while idle (R7)
        for (int a = 0; a < 2048; a++) begin
            @(negedge clk);
            tbl_we   = 1'b1;
            tbl_sel  = (a >= 1024);
            tbl_addr = 10'(a % 1024);
            tbl_data = (a >= 1024) ? lo_m[a % 1024] : hi_m[a % 1024];
        end
        @(negedge clk);
        tbl_we = 1'b0;

        // class sweep over lines with shifting bit alignment (R1 R2 R3)
        for (int ln = 0; ln < 10; ln++) begin
            if (ln == 6) begin
                // idle rewrite of low entries must take effect (R7)
                for (int a = 0; a < 16; a++) begin
                    @(negedge clk);
                    tbl_we   = 1'b1;
                    tbl_sel  = (a >= 8);
                    tbl_addr = 10'(a % 8);
                    tbl_data = 16'(16'h7100 + a * 3);
                    if (a >= 8) lo_m[a % 8] = 16'(16'h7100 + a * 3);
                    else        hi_m[a % 8] = 16'(16'h7100 + a * 3);
                end
                @(negedge clk);
                tbl_we = 1'b0;
            end
            build_line(ln, 1'b0);
            // during line 3 writes are attempted mid-fill; lines 4 and 6 prove R7
            run_line(1'b0, ln, ln == 3,
                     (ln == 4 || ln == 6) ? "R7" : "R1 R2 R3");
        end

        // dense line: 7-bit instructions, zero lower halves (R2 R5)
        build_line(10, 1'b1);
        run_line(1'b0, 11, 1'b0, "R2");

        // raw lines, then a compressed one after them (R6)
        build_raw(1);
        run_line(1'b1, 2, 1'b0, "R6");
        build_raw(2);
        run_line(1'b1, 3, 1'b0, "R6");
        build_line(12, 1'b0);
        run_line(1'b0, 4, 1'b0, "R3");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule